// File: doc/BRIEF.md
# Local Interrupt Controller Register File

This block is the software-visible register file of a per-processor interrupt controller. A processor reaches it over a simple 32-bit bus. The bus carries a write strobe and a read strobe, a byte offset and write data. Read data is registered and returned one cycle after the read strobe.

The file holds five registers:
- a processor ID register;
- an end-of-interrupt register that can only be written;
- an enable register that also holds the spurious vector;
- two 32-bit words of a command register used for interprocessor messages.

Writing the low command word launches an outgoing message on a valid/ready port. The message is built from the low word's fields and from the destination held in the high word at that moment. A read-only pending bit stays set until the receiver accepts the message. Any write to the end-of-interrupt offset produces a one-cycle strobe.

Top module: `lic_regfile`

## Requirements
- R1: After reset, ID reads 0x00000000, the spurious register reads 0x0000000F (controller disabled), both command words read 0, and `ipi_valid` and `eoi_pulse` are 0.
- R2: A write to offset 0x020 stores bits 31:24 as the ID. Reads of that offset return the ID in bits 31:24 and zero elsewhere.
- R3: Any write to offset 0x0B0, whatever its data, drives `eoi_pulse` high for exactly the cycle after the write edge. Reads of 0x0B0 return zero.
- R4: Offset 0x0F0 stores the enable in bit 8 (1 = enabled) and the spurious vector bits 7:4. Reads return bits 3:0 as 1s and bits 31:9 as zero.
- R5: Offset 0x310 stores the destination in bits 31:24. Reads return it there, with zero in bits 23:0.
- R6: When the controller is enabled and no message is pending, a write to offset 0x300 raises `ipi_valid` in the next cycle. The message outputs carry the written fields, all of which are then readable at 0x300:
  - vector: bits 7:0
  - delivery mode: bits 10:8 (110 = start-up, 101 = INIT)
  - logical destination mode: bit 11
  - level: bit 14
  - trigger: bit 15
  - shorthand: bits 19:18 (11 = all excluding self)

  While pending, bit 12 reads 1. Other bits read 0, and written values of bit 12 are ignored.
- R7: While `ipi_valid` is high and `ipi_ready` is low, every message output holds its value.
- R8: At a clock edge with `ipi_valid` and `ipi_ready` both high, the message is accepted. `ipi_valid` and read bit 12 are 0 from the next cycle.
- R9: While the controller is disabled, writes to 0x300 are ignored: no message is launched and the low word reads unchanged.
- R10: A write to 0x300 while a message is pending is dropped. The pending message and the low word's readback are unchanged.
- R11: The message destination is captured at launch. A later write to 0x310 changes the readback but not the in-flight `ipi_dest`.
- R12: Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| eoi_pulse | output | 1 | One-cycle end-of-interrupt strobe |
| ipi_valid | output | 1 | Outgoing message valid (pending) |
| ipi_ready | input | 1 | Receiver accepts the message |
| ipi_vector | output | 8 | Message vector |
| ipi_mode | output | 3 | Delivery mode |
| ipi_logical | output | 1 | 1 = logical destination mode |
| ipi_level | output | 1 | Level (1 = assert) |
| ipi_trigger | output | 1 | Trigger (1 = level) |
| ipi_shorthand | output | 2 | Destination shorthand |
| ipi_dest | output | 8 | Destination captured at launch |

## Verification
Every result passes through exactly one register:
- read data appears the cycle after the read strobe's edge;
- `eoi_pulse` and `ipi_valid` rise the cycle after the write edge;
- `ipi_valid` falls the cycle after the edge where ready is seen.

The bench drives inputs at falling edges and samples at the falling edge that follows the capturing rising edge. Expected read values go into a scoreboard queue, and a monitor pops them one cycle after each read strobe. Stability while stalled is checked at each falling edge of the stall.

// File: rtl/lic_pkg.sv
package lic_pkg;

    // Byte offsets of the mapped registers (behaviour depends on these)
    localparam logic [11:0] OFS_ID     = 12'h020;
    localparam logic [11:0] OFS_EOI    = 12'h0B0;
    localparam logic [11:0] OFS_SPUR   = 12'h0F0;
    localparam logic [11:0] OFS_CMD_LO = 12'h300;
    localparam logic [11:0] OFS_CMD_HI = 12'h310;

    localparam int DATA_W = 32;
    localparam int ID_W   = 8;
    localparam int VEC_W  = 8;

    typedef enum logic [2:0] {
        DM_FIXED  = 3'b000,
        DM_LOWEST = 3'b001,
        DM_SMI    = 3'b010,
        DM_RSV3   = 3'b011,
        DM_NMI    = 3'b100,
        DM_INIT   = 3'b101,
        DM_START  = 3'b110,
        DM_RSV7   = 3'b111
    } dlv_mode_e;

    typedef enum logic [1:0] {
        SH_NONE    = 2'b00,
        SH_SELF    = 2'b01,
        SH_ALL_INC = 2'b10,
        SH_ALL_EXC = 2'b11
    } short_e;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ID,
        SEL_EOI,
        SEL_SPUR,
        SEL_CMD_LO,
        SEL_CMD_HI
    } reg_sel_e;

    typedef struct packed {
        short_e             shorthand;
        logic               trigger;
        logic               level;
        logic               logical;
        dlv_mode_e          mode;
        logic [VEC_W-1:0]   vector;
    } ipi_ctl_t;

    typedef struct packed {
        logic [ID_W-1:0]    dest;
        ipi_ctl_t           ctl;
    } ipi_msg_t;

    // Low command word image: control fields plus the pending status
    function automatic logic [DATA_W-1:0] pack_cmd_lo(input ipi_ctl_t c, input logic pend);
        return {12'h000, c.shorthand, 2'b00, c.trigger, c.level, 1'b0,
                pend, c.logical, c.mode, c.vector};
    endfunction

    // Spurious/enable word: low nibble of the vector always reads as ones
    function automatic logic [DATA_W-1:0] pack_spur(input logic en, input logic [3:0] vhi);
        return {23'h0, en, vhi, 4'hF};
    endfunction

endpackage

// File: rtl/lic_addr_dec.sv
module lic_addr_dec
    import lic_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    localparam logic [ADDR_W-1:0] A_ID  = ADDR_W'(OFS_ID);
    localparam logic [ADDR_W-1:0] A_EOI = ADDR_W'(OFS_EOI);
    localparam logic [ADDR_W-1:0] A_SP  = ADDR_W'(OFS_SPUR);
    localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(OFS_CMD_LO);
    localparam logic [ADDR_W-1:0] A_HI  = ADDR_W'(OFS_CMD_HI);

    always_comb begin
        if      (addr == A_ID)  sel = SEL_ID;
        else if (addr == A_EOI) sel = SEL_EOI;
        else if (addr == A_SP)  sel = SEL_SPUR;
        else if (addr == A_LO)  sel = SEL_CMD_LO;
        else if (addr == A_HI)  sel = SEL_CMD_HI;
        else                    sel = SEL_NONE;
    end
endmodule

// File: rtl/lic_local_cfg.sv
module lic_local_cfg
    import lic_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_id,
    input  logic             wr_spur,
    input  logic [ID_W-1:0]  id_in,
    input  logic             en_in,
    input  logic [3:0]       vhi_in,
    output logic [ID_W-1:0]  id_q,
    output logic             en_q,
    output logic [3:0]       vhi_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            id_q  <= '0;
            en_q  <= 1'b0;
            vhi_q <= 4'h0;
        end else begin
            if (wr_id) begin
                id_q <= id_in;
            end
            if (wr_spur) begin
                en_q  <= en_in;
                vhi_q <= vhi_in;
            end
        end
    end
endmodule

// File: rtl/lic_ipi_cmd.sv
module lic_ipi_cmd
    import lic_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic             enabled,
    input  ipi_ctl_t         ctl_in,
    input  logic [ID_W-1:0]  dest_in,
    input  logic             ready,
    output logic             pending,
    output ipi_msg_t         msg,
    output logic [ID_W-1:0]  hi_dest
);
    logic launch;
    logic accept;

    assign launch = wr_lo && enabled && !pending;
    assign accept = pending && ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_dest <= '0;
        end else if (wr_hi) begin
            hi_dest <= dest_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            msg     <= '0;
        end else if (launch) begin
            pending  <= 1'b1;
            msg.ctl  <= ctl_in;
            msg.dest <= hi_dest;
        end else if (accept) begin
            pending <= 1'b0;
        end
    end
endmodule

// File: rtl/lic_regfile.sv
module lic_regfile
    import lic_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              eoi_pulse,
    output logic              ipi_valid,
    input  logic              ipi_ready,
    output logic [7:0]        ipi_vector,
    output logic [2:0]        ipi_mode,
    output logic              ipi_logical,
    output logic              ipi_level,
    output logic              ipi_trigger,
    output logic [1:0]        ipi_shorthand,
    output logic [7:0]        ipi_dest
);
    reg_sel_e          sel;
    logic [ID_W-1:0]   id_q;
    logic              cfg_en;
    logic [3:0]        vhi_q;
    logic              pend;
    ipi_msg_t          msg;
    logic [ID_W-1:0]   hi_dest;
    ipi_ctl_t          ctl_in;
    logic [DATA_W-1:0] rd_word;
    logic              unused_wdata;

    assign unused_wdata = ^{bus_wdata[23:20], bus_wdata[17:16], bus_wdata[13:12]};

    always_comb begin
        ctl_in.vector    = bus_wdata[7:0];
        ctl_in.mode      = dlv_mode_e'(bus_wdata[10:8]);
        ctl_in.logical   = bus_wdata[11];
        ctl_in.level     = bus_wdata[14];
        ctl_in.trigger   = bus_wdata[15];
        ctl_in.shorthand = short_e'(bus_wdata[19:18]);
    end

    lic_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    lic_local_cfg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_id   (bus_wr && sel == SEL_ID),
        .wr_spur (bus_wr && sel == SEL_SPUR),
        .id_in   (bus_wdata[31:24]),
        .en_in   (bus_wdata[8]),
        .vhi_in  (bus_wdata[7:4]),
        .id_q    (id_q),
        .en_q    (cfg_en),
        .vhi_q   (vhi_q)
    );

    lic_ipi_cmd u_cmd (
        .clk     (clk),
        .rst     (rst),
        .wr_lo   (bus_wr && sel == SEL_CMD_LO),
        .wr_hi   (bus_wr && sel == SEL_CMD_HI),
        .enabled (cfg_en),
        .ctl_in  (ctl_in),
        .dest_in (bus_wdata[31:24]),
        .ready   (ipi_ready),
        .pending (pend),
        .msg     (msg),
        .hi_dest (hi_dest)
    );

    always_comb begin
        unique case (sel)
            SEL_ID:     rd_word = {id_q, 24'h0};
            SEL_SPUR:   rd_word = pack_spur(cfg_en, vhi_q);
            SEL_CMD_LO: rd_word = pack_cmd_lo(msg.ctl, pend);
            SEL_CMD_HI: rd_word = {hi_dest, 24'h0};
            default:    rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
            eoi_pulse <= 1'b0;
        end else begin
            if (bus_rd) begin
                bus_rdata <= rd_word;
            end
            eoi_pulse <= bus_wr && (sel == SEL_EOI);
        end
    end

    assign ipi_valid     = pend;
    assign ipi_vector    = msg.ctl.vector;
    assign ipi_mode      = msg.ctl.mode;
    assign ipi_logical   = msg.ctl.logical;
    assign ipi_level     = msg.ctl.level;
    assign ipi_trigger   = msg.ctl.trigger;
    assign ipi_shorthand = msg.ctl.shorthand;
    assign ipi_dest      = msg.dest;
endmodule

// File: rtl/lic_regfile_chk.sv
module lic_regfile_chk
    import lic_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              eoi_pulse,
    input logic              ipi_valid,
    input logic              ipi_ready,
    input logic [7:0]        ipi_vector,
    input logic [2:0]        ipi_mode,
    input logic              ipi_logical,
    input logic              ipi_level,
    input logic              ipi_trigger,
    input logic [1:0]        ipi_shorthand,
    input logic [7:0]        ipi_dest,
    input logic              cfg_en
);
    localparam logic [ADDR_W-1:0] A_EOI = ADDR_W'(OFS_EOI);
    localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(OFS_CMD_LO);

    AST_EOI_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        eoi_pulse |-> $past(bus_wr && bus_addr == A_EOI)); // R3

    AST_MSG_HELD: assert property (@(posedge clk) disable iff (rst)
        (ipi_valid && !ipi_ready) |=> (ipi_valid && $stable({ipi_vector, ipi_mode,
            ipi_logical, ipi_level, ipi_trigger, ipi_shorthand, ipi_dest}))); // R7

    AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (ipi_valid && ipi_ready) |=> !ipi_valid); // R8

    AST_LAUNCH_ENABLED: assert property (@(posedge clk) disable iff (rst)
        $rose(ipi_valid) |-> $past(cfg_en && bus_wr && bus_addr == A_LO)); // R9

    AST_STATUS_READ: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == A_LO) |=> (bus_rdata[12] == $past(ipi_valid))); // R6
endmodule

bind lic_regfile lic_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .bus_wr        (bus_wr),
    .bus_rd        (bus_rd),
    .bus_addr      (bus_addr),
    .bus_rdata     (bus_rdata),
    .eoi_pulse     (eoi_pulse),
    .ipi_valid     (ipi_valid),
    .ipi_ready     (ipi_ready),
    .ipi_vector    (ipi_vector),
    .ipi_mode      (ipi_mode),
    .ipi_logical   (ipi_logical),
    .ipi_level     (ipi_level),
    .ipi_trigger   (ipi_trigger),
    .ipi_shorthand (ipi_shorthand),
    .ipi_dest      (ipi_dest),
    .cfg_en        (cfg_en)
);

// File: tb/lic_regfile_tb.sv
module lic_regfile_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        eoi_pulse;
    logic        ipi_valid;
    logic        ipi_ready = 1'b0;
    logic [7:0]  ipi_vector;
    logic [2:0]  ipi_mode;
    logic        ipi_logical;
    logic        ipi_level;
    logic        ipi_trigger;
    logic [1:0]  ipi_shorthand;
    logic [7:0]  ipi_dest;

    int total = 0;
    int bad   = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    always #5 clk = ~clk;

    lic_regfile u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eoi_pulse(eoi_pulse), .ipi_valid(ipi_valid), .ipi_ready(ipi_ready),
        .ipi_vector(ipi_vector), .ipi_mode(ipi_mode), .ipi_logical(ipi_logical),
        .ipi_level(ipi_level), .ipi_trigger(ipi_trigger),
        .ipi_shorthand(ipi_shorthand), .ipi_dest(ipi_dest)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_read(input logic [11:0] a, input logic [31:0] exp, input string req);
        exp_q.push_back(exp);
        tag_q.push_back(req);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic check_msg(input string req, input logic [7:0] v, input logic [2:0] m,
                             input logic lg, input logic lv, input logic tr,
                             input logic [1:0] sh, input logic [7:0] d);
        check(req, {31'h0, ipi_valid}, 32'h1);
        check(req, {ipi_dest, ipi_shorthand, ipi_trigger, ipi_level, ipi_logical,
                    ipi_mode, ipi_vector}, {d, sh, tr, lv, lg, m, v});
    endtask

    // Scoreboard monitor: read data is due one cycle after the read edge
    always @(posedge clk) rd_seen <= bus_rd;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                check("scoreboard", 32'h1, 32'h0);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 valid", {31'h0, ipi_valid}, 32'h0);
        check("R1 eoi", {31'h0, eoi_pulse}, 32'h0);
        do_read(12'h020, 32'h0000_0000, "R1 id");
        do_read(12'h0F0, 32'h0000_000F, "R1 spur");
        do_read(12'h300, 32'h0000_0000, "R1 lo");
        do_read(12'h310, 32'h0000_0000, "R1 hi");
        // R2 ID
        do_write(12'h020, 32'hA5FF_FFFF);
        do_read(12'h020, 32'hA500_0000, "R2 id");
        // R3 EOI
        do_write(12'h0B0, 32'h1234_5678);
        check("R3 pulse high", {31'h0, eoi_pulse}, 32'h1);
        @(negedge clk);
        check("R3 pulse one cycle", {31'h0, eoi_pulse}, 32'h0);
        do_read(12'h0B0, 32'h0, "R3 read zero");
        // R4 spurious, still disabled
        do_write(12'h0F0, 32'hFFFF_FE30);
        do_read(12'h0F0, 32'h0000_003F, "R4 spur disabled");
        // R9 disabled: launch ignored
        do_write(12'h300, 32'h000C_4611);
        check("R9 no launch", {31'h0, ipi_valid}, 32'h0);
        do_read(12'h300, 32'h0, "R9 lo unchanged");
        // R4 enable
        do_write(12'h0F0, 32'h0000_01A0);
        do_read(12'h0F0, 32'h0000_01AF, "R4 spur enabled");
        // R5 destination word
        do_write(12'h310, 32'hFFFF_FFFF);
        do_read(12'h310, 32'hFF00_0000, "R5 hi mask");
        do_write(12'h310, 32'h3C00_0000);
        do_read(12'h310, 32'h3C00_0000, "R5 hi");
        // R6 launch: start-up, vector 11, level 1, all excluding self
        do_write(12'h300, 32'h000C_4611);
        check_msg("R6 launch", 8'h11, 3'b110, 1'b0, 1'b1, 1'b0, 2'b11, 8'h3C);
        do_read(12'h300, 32'h000C_5611, "R6 pending readback");
        // R7 held while stalled
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check_msg("R7 stall", 8'h11, 3'b110, 1'b0, 1'b1, 1'b0, 2'b11, 8'h3C);
        end
        // R11 destination snapshot
        do_write(12'h310, 32'h7700_0000);
        check("R11 dest held", {24'h0, ipi_dest}, 32'h3C);
        do_read(12'h310, 32'h7700_0000, "R11 hi readback");
        // R10 write while pending dropped
        do_write(12'h300, 32'h0000_C822);
        check_msg("R10 dropped", 8'h11, 3'b110, 1'b0, 1'b1, 1'b0, 2'b11, 8'h3C);
        do_read(12'h300, 32'h000C_5611, "R10 lo unchanged");
        // R8 accept
        @(negedge clk);
        ipi_ready = 1'b1;
        @(negedge clk);
        check("R8 cleared", {31'h0, ipi_valid}, 32'h0);
        ipi_ready = 1'b0;
        do_read(12'h300, 32'h000C_4611, "R8 idle readback");
        // R6/R8 second launch with ready held high: INIT, logical, level trigger
        ipi_ready = 1'b1;
        do_write(12'h300, 32'h0000_CD22);
        check_msg("R6 second launch", 8'h22, 3'b101, 1'b1, 1'b1, 1'b1, 2'b00, 8'h77);
        @(negedge clk);
        check("R8 one-cycle accept", {31'h0, ipi_valid}, 32'h0);
        ipi_ready = 1'b0;
        // R12 unmapped
        do_read(12'h100, 32'h0, "R12 unmapped");
        do_read(12'h304, 32'h0, "R12 unmapped near cmd");
        // R9 disable again, then launch ignored
        do_write(12'h0F0, 32'h0000_0000);
        do_write(12'h300, 32'h0008_0633);
        check("R9 disabled again", {31'h0, ipi_valid}, 32'h0);
        do_read(12'h300, 32'h0000_CD22, "R9 lo kept");
        repeat (3) @(negedge clk);
        check("scoreboard drained", exp_q.size(), 32'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule